// File: doc/BRIEF.md
# DMA Transfer Setup Register Bank

This block is the software-facing control bank for a single-request DMA engine. A host on an AXI4-Lite slave port programs the destination and source addresses, the horizontal and vertical lengths, the two strides and a pair of flag bits. It sets the enable bit and then writes the submit register. The bank presents the programmed descriptor on a request channel toward the transfer engine. It holds request valid high until the engine takes the descriptor. Only one request is outstanding at a time.

The engine sends back a one-cycle end-of-transfer pulse when it finishes. The bank uses request acceptance and completion to keep a next-ID counter, an active-ID counter and one done bit per ID. The same two events feed a two-source interrupt block. That block has a mask, a raw source register, a masked pending view and write-one-to-clear. Identification constants, a scratch word and read-only views of the engine's debug inputs complete the map.

Back-pressure on the request channel works as follows. While `req_ready` is low, `req_valid` and the descriptor fields stay unchanged. A transfer is handed over on the first rising clock edge where both `req_valid` and `req_ready` are high.

Top module: `dma_regbank`

## Requirements
- R1: After reset, offset 0x000 reads 0x00040161, offset 0x00C reads 0x444D4143, the interrupt mask (0x080) reads 0x3, the flags (0x40C) read 0x3 and the X length (0x418) reads 0x3. Every other offset reads 0.
- R2: The scratch word at 0x008 stores all 32 bits. Any offset not named in these requirements reads 0, and writing it changes nothing.
- R3: Bit 0 of the destination address (0x410), the source address (0x414), the destination stride (0x420) and the source stride (0x424) always reads 0. The strides and the Y length (0x41C) hold 24 bits. The X length (0x418) holds 24 bits and its bits 1:0 always read 1. Each value also appears on the matching request output.
- R4: On the write channel, address and data may arrive in either order. The register changes on the clock edge after the later of the two is accepted. `bresp` is 0 (OKAY), and `bvalid` holds until `bready` is high. While a response is pending, `awready` and `wready` are low.
- R5: On the read channel, `rvalid` rises one cycle after the address handshake, with `rresp` 0. `rvalid` and `rdata` hold until `rready` is high.
- R6: A write with bit 0 set to the submit register (0x408) raises `req_valid` and makes 0x408 read 1, but only while enable (0x400 bit 0) is 1. Otherwise the write has no effect. `req_last` follows flags bit 1.
- R7: `req_valid` stays high until acceptance. On acceptance, 0x408 returns to 0, the next ID (0x404, 4 bits) increments modulo 16, and raw interrupt bit 0 sets.
- R8: An `xfer_end` pulse sets raw interrupt bit 1 and sets done bit n in 0x428, where n is the active ID (0x42C, 4 bits). The active ID then increments modulo 16. Accepting a transfer with ID n clears done bit n.
- R9: 0x088 reads the raw interrupt bits. 0x084 reads raw AND NOT mask, where a mask bit of 1 blocks that source. Writing 1 to a bit of 0x084 clears that raw bit. `irq` is the OR of the bits of 0x084.
- R10: Offsets 0x434, 0x438, 0x43C, 0x440 and 0x444 read the destination debug address, the source debug address, the 8-bit status (zero-extended) and the two ID words. Writes to these offsets are ignored.
- R11: Holding `rst_n` low through a rising edge restores every register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 12 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 12 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| req_valid | output | 1 | Descriptor valid toward the engine |
| req_ready | input | 1 | Engine takes the descriptor |
| req_dst_addr | output | 32 | Destination address |
| req_src_addr | output | 32 | Source address |
| req_x_len | output | 24 | X length |
| req_y_len | output | 24 | Y length |
| req_dst_stride | output | 24 | Destination stride |
| req_src_stride | output | 24 | Source stride |
| req_last | output | 1 | Flags bit 1 |
| xfer_end | input | 1 | End-of-transfer pulse |
| dbg_dst_addr | input | 32 | Debug destination address |
| dbg_src_addr | input | 32 | Debug source address |
| dbg_status | input | 8 | Debug status |
| dbg_id0 | input | 32 | Debug ID word 0 |
| dbg_id1 | input | 32 | Debug ID word 1 |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach from the ports is ID wrap-around. The next-ID and active-ID counters must both pass 15 back to 0, and each done bit must be cleared by a new acceptance after an earlier completion set it. The stimulus reaches this by running seventeen back-to-back submit, accept and end cycles, reading the ID and done registers after each one. Write ordering and response back-pressure are reached by presenting address before data, data before address, and a held-low `bready`. A reference model in the bench tracks `req_valid`, `irq` and the descriptor on every clock.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int REG_AW = 12;
  localparam int DW     = 32;

  localparam logic [REG_AW-1:0] OFS_VERSION  = 12'h000;
  localparam logic [REG_AW-1:0] OFS_SCRATCH  = 12'h008;
  localparam logic [REG_AW-1:0] OFS_IDENT    = 12'h00C;
  localparam logic [REG_AW-1:0] OFS_IRQ_MASK = 12'h080;
  localparam logic [REG_AW-1:0] OFS_IRQ_PEND = 12'h084;
  localparam logic [REG_AW-1:0] OFS_IRQ_RAW  = 12'h088;
  localparam logic [REG_AW-1:0] OFS_CTRL     = 12'h400;
  localparam logic [REG_AW-1:0] OFS_NEXT_ID  = 12'h404;
  localparam logic [REG_AW-1:0] OFS_SUBMIT   = 12'h408;
  localparam logic [REG_AW-1:0] OFS_FLAGS    = 12'h40C;
  localparam logic [REG_AW-1:0] OFS_DST      = 12'h410;
  localparam logic [REG_AW-1:0] OFS_SRC      = 12'h414;
  localparam logic [REG_AW-1:0] OFS_XLEN     = 12'h418;
  localparam logic [REG_AW-1:0] OFS_YLEN     = 12'h41C;
  localparam logic [REG_AW-1:0] OFS_DSTRIDE  = 12'h420;
  localparam logic [REG_AW-1:0] OFS_SSTRIDE  = 12'h424;
  localparam logic [REG_AW-1:0] OFS_DONE     = 12'h428;
  localparam logic [REG_AW-1:0] OFS_ACTIVE   = 12'h42C;
  localparam logic [REG_AW-1:0] OFS_DBG_DST  = 12'h434;
  localparam logic [REG_AW-1:0] OFS_DBG_SRC  = 12'h438;
  localparam logic [REG_AW-1:0] OFS_DBG_STAT = 12'h43C;
  localparam logic [REG_AW-1:0] OFS_DBG_ID0  = 12'h440;
  localparam logic [REG_AW-1:0] OFS_DBG_ID1  = 12'h444;

  localparam int NUM_IRQ       = 2;
  localparam int IRQ_BIT_START = 0;
  localparam int IRQ_BIT_END   = 1;

  typedef logic [NUM_IRQ-1:0] irq_vec_t;
endpackage

// File: rtl/dmarb_axil_port.sv
module dmarb_axil_port #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          awvalid,
  output logic          awready,
  input  logic [AW-1:0] awaddr,
  input  logic          wvalid,
  output logic          wready,
  input  logic [DW-1:0] wdata,
  output logic          bvalid,
  input  logic          bready,
  output logic [1:0]    bresp,
  input  logic          arvalid,
  output logic          arready,
  input  logic [AW-1:0] araddr,
  output logic          rvalid,
  input  logic          rready,
  output logic [DW-1:0] rdata,
  output logic [1:0]    rresp,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_word
);
  logic          aw_full, w_full;
  logic [AW-1:0] aw_q;
  logic [DW-1:0] w_q;

  assign awready = !aw_full && !bvalid;
  assign wready  = !w_full && !bvalid;
  assign wr_en   = aw_full && w_full;
  assign wr_addr = aw_q;
  assign wr_data = w_q;
  assign bresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full <= 1'b0;
      w_full  <= 1'b0;
      aw_q    <= '0;
      w_q     <= '0;
      bvalid  <= 1'b0;
    end else begin
      if (awvalid && awready) begin
        aw_full <= 1'b1;
        aw_q    <= awaddr;
      end
      if (wvalid && wready) begin
        w_full <= 1'b1;
        w_q    <= wdata;
      end
      if (wr_en) begin
        aw_full <= 1'b0;
        w_full  <= 1'b0;
        bvalid  <= 1'b1;
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end

  assign arready = !rvalid;
  assign rd_addr = araddr;
  assign rresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (arvalid && arready) begin
      rvalid <= 1'b1;
      rdata  <= rd_word;
    end else if (rvalid && rready) begin
      rvalid <= 1'b0;
    end
  end

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid); // R4
  AST_R_AFTER_AR: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && arready |=> rvalid); // R5
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata)); // R5
endmodule

// File: rtl/dmarb_xfer_track.sv
module dmarb_xfer_track #(
  parameter int ID_W = 4,
  localparam int NIDS = 1 << ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            submit,
  input  logic            req_ready,
  input  logic            xfer_end,
  output logic            req_valid,
  output logic [ID_W-1:0] next_id,
  output logic [ID_W-1:0] active_id,
  output logic [NIDS-1:0] done_bits,
  output logic            start_evt,
  output logic            end_evt
);
  logic pending;
  logic accept;

  assign accept    = pending && req_ready;
  assign req_valid = pending;
  assign start_evt = accept;
  assign end_evt   = xfer_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      next_id   <= '0;
      active_id <= '0;
    end else begin
      pending <= (submit && enable) || (pending && !accept);
      if (accept)   next_id   <= next_id + 1'b1;
      if (xfer_end) active_id <= active_id + 1'b1;
    end
  end

  for (genvar gi = 0; gi < NIDS; gi++) begin : g_done
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_bits[gi] <= 1'b0;
      end else begin
        done_bits[gi] <= (done_bits[gi] && !(accept && next_id == ID_W'(gi)))
                         || (xfer_end && active_id == ID_W'(gi));
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid); // R7
  AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> next_id == $past(next_id) + 1'b1); // R7
  AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !submit |=> !req_valid); // R7
  AST_NO_SUBMIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !req_valid |=> !req_valid); // R6
  AST_DONE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> done_bits[$past(active_id)]); // R8
endmodule

// File: rtl/dmarb_irq.sv
module dmarb_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~clr_vec) | set_vec;
  end

  assign pend = raw & ~mask;
  assign irq  = |pend;

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    |set_vec |=> (raw & $past(set_vec)) == $past(set_vec)); // R9
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr_vec & ~set_vec) |=> (raw & $past(clr_vec & ~set_vec)) == '0); // R9
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int          BPB_W     = 1,
  parameter int          LEN_W     = 24,
  parameter int          LEN_ALIGN = 2,
  parameter int          ID_W      = 4,
  parameter logic [31:0] VERSION   = 32'h0004_0161,
  parameter logic [31:0] IDENT     = 32'h444D_4143
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [11:0]       s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [31:0]       s_wdata,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [11:0]       s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [31:0]       req_dst_addr,
  output logic [31:0]       req_src_addr,
  output logic [LEN_W-1:0]  req_x_len,
  output logic [LEN_W-1:0]  req_y_len,
  output logic [LEN_W-1:0]  req_dst_stride,
  output logic [LEN_W-1:0]  req_src_stride,
  output logic              req_last,
  input  logic              xfer_end,
  input  logic [31:0]       dbg_dst_addr,
  input  logic [31:0]       dbg_src_addr,
  input  logic [7:0]        dbg_status,
  input  logic [31:0]       dbg_id0,
  input  logic [31:0]       dbg_id1,
  output logic              irq
);
  localparam int NIDS = 1 << ID_W;
  localparam logic [31:0]      ADDR_KEEP   = {{(32-BPB_W){1'b1}}, {BPB_W{1'b0}}};
  localparam logic [LEN_W-1:0] STRIDE_KEEP = {{(LEN_W-BPB_W){1'b1}}, {BPB_W{1'b0}}};
  localparam logic [LEN_W-1:0] LEN_ONES    = {{(LEN_W-LEN_ALIGN){1'b0}}, {LEN_ALIGN{1'b1}}};

  logic              wr_en;
  logic [11:0]       wr_addr, rd_addr, wr_word, rd_sel;
  logic [31:0]       wr_data, rd_word;

  logic [31:0]       scratch_q, dst_q, src_q;
  logic [LEN_W-1:0]  xlen_q, ylen_q, dstride_q, sstride_q;
  irq_vec_t          mask_q, flags_q, irq_raw, irq_pend, irq_clr, irq_set;
  logic              enable_q;
  logic              submit_wr, start_evt, end_evt;
  logic [ID_W-1:0]   next_id, active_id;
  logic [NIDS-1:0]   done_bits;

  dmarb_axil_port #(.AW(REG_AW), .DW(DW)) u_port (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  assign wr_word = {wr_addr[11:2], 2'b00};
  assign rd_sel  = {rd_addr[11:2], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_q <= '0;
      mask_q    <= '1;
      enable_q  <= 1'b0;
      flags_q   <= '1;
      dst_q     <= '0;
      src_q     <= '0;
      xlen_q    <= LEN_ONES;
      ylen_q    <= '0;
      dstride_q <= '0;
      sstride_q <= '0;
    end else if (wr_en) begin
      case (wr_word)
        OFS_SCRATCH:  scratch_q <= wr_data;
        OFS_IRQ_MASK: mask_q    <= wr_data[NUM_IRQ-1:0];
        OFS_CTRL:     enable_q  <= wr_data[0];
        OFS_FLAGS:    flags_q   <= wr_data[1:0];
        OFS_DST:      dst_q     <= wr_data & ADDR_KEEP;
        OFS_SRC:      src_q     <= wr_data & ADDR_KEEP;
        OFS_XLEN:     xlen_q    <= wr_data[LEN_W-1:0] | LEN_ONES;
        OFS_YLEN:     ylen_q    <= wr_data[LEN_W-1:0];
        OFS_DSTRIDE:  dstride_q <= wr_data[LEN_W-1:0] & STRIDE_KEEP;
        OFS_SSTRIDE:  sstride_q <= wr_data[LEN_W-1:0] & STRIDE_KEEP;
        default: ;
      endcase
    end
  end

  assign submit_wr = wr_en && (wr_word == OFS_SUBMIT) && wr_data[0];
  assign irq_clr   = (wr_en && wr_word == OFS_IRQ_PEND) ? wr_data[NUM_IRQ-1:0] : '0;

  dmarb_xfer_track #(.ID_W(ID_W)) u_track (
    .clk(clk), .rst_n(rst_n), .enable(enable_q), .submit(submit_wr),
    .req_ready(req_ready), .xfer_end(xfer_end), .req_valid(req_valid),
    .next_id(next_id), .active_id(active_id), .done_bits(done_bits),
    .start_evt(start_evt), .end_evt(end_evt)
  );

  always_comb begin
    irq_set = '0;
    irq_set[IRQ_BIT_START] = start_evt;
    irq_set[IRQ_BIT_END]   = end_evt;
  end

  dmarb_irq #(.NSRC(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(irq_set), .clr_vec(irq_clr),
    .mask(mask_q), .raw(irq_raw), .pend(irq_pend), .irq(irq)
  );

  always_comb begin
    case (rd_sel)
      OFS_VERSION:  rd_word = VERSION;
      OFS_SCRATCH:  rd_word = scratch_q;
      OFS_IDENT:    rd_word = IDENT;
      OFS_IRQ_MASK: rd_word = 32'(mask_q);
      OFS_IRQ_PEND: rd_word = 32'(irq_pend);
      OFS_IRQ_RAW:  rd_word = 32'(irq_raw);
      OFS_CTRL:     rd_word = 32'(enable_q);
      OFS_NEXT_ID:  rd_word = 32'(next_id);
      OFS_SUBMIT:   rd_word = 32'(req_valid);
      OFS_FLAGS:    rd_word = 32'(flags_q);
      OFS_DST:      rd_word = dst_q;
      OFS_SRC:      rd_word = src_q;
      OFS_XLEN:     rd_word = 32'(xlen_q);
      OFS_YLEN:     rd_word = 32'(ylen_q);
      OFS_DSTRIDE:  rd_word = 32'(dstride_q);
      OFS_SSTRIDE:  rd_word = 32'(sstride_q);
      OFS_DONE:     rd_word = 32'(done_bits);
      OFS_ACTIVE:   rd_word = 32'(active_id);
      OFS_DBG_DST:  rd_word = dbg_dst_addr;
      OFS_DBG_SRC:  rd_word = dbg_src_addr;
      OFS_DBG_STAT: rd_word = 32'(dbg_status);
      OFS_DBG_ID0:  rd_word = dbg_id0;
      OFS_DBG_ID1:  rd_word = dbg_id1;
      default:      rd_word = '0;
    endcase
  end

  assign req_dst_addr   = dst_q;
  assign req_src_addr   = src_q;
  assign req_x_len      = xlen_q;
  assign req_y_len      = ylen_q;
  assign req_dst_stride = dstride_q;
  assign req_src_stride = sstride_q;
  assign req_last       = flags_q[1];

  logic unused_bits;
  assign unused_bits = ^{wr_addr[1:0], rd_addr[1:0], flags_q[0], wr_data};

  AST_DESC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !wr_en |=> $stable(req_dst_addr) && $stable(req_x_len)); // R7
endmodule

// File: tb/dma_regbank_tb.sv
module dma_regbank_tb;
  localparam logic [31:0] DBG_DST = 32'hFEDC_BA98;
  localparam logic [31:0] DBG_SRC = 32'h7654_3210;
  localparam logic [7:0]  DBG_ST  = 8'hA5;
  localparam logic [31:0] DBG_I0  = 32'h0123_4567;
  localparam logic [31:0] DBG_I1  = 32'h89AB_CDEF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
  logic [11:0] s_awaddr = 0, s_araddr = 0;
  logic [31:0] s_wdata = 0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic        req_valid, req_ready = 0, req_last, xfer_end = 0, irq;
  logic [31:0] req_dst_addr, req_src_addr;
  logic [23:0] req_x_len, req_y_len, req_dst_stride, req_src_stride;

  dma_regbank u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_dst_addr(req_dst_addr), .req_src_addr(req_src_addr),
    .req_x_len(req_x_len), .req_y_len(req_y_len),
    .req_dst_stride(req_dst_stride), .req_src_stride(req_src_stride),
    .req_last(req_last), .xfer_end(xfer_end),
    .dbg_dst_addr(DBG_DST), .dbg_src_addr(DBG_SRC), .dbg_status(DBG_ST),
    .dbg_id0(DBG_I0), .dbg_id1(DBG_I1), .irq(irq)
  );

  int checks = 0, errors = 0;

  // reference model state
  logic [31:0] m_scr, m_dst, m_src, m_xl, m_yl, m_ds, m_ss;
  logic [1:0]  m_mask, m_flags, m_raw;
  logic        m_en, m_pend;
  int          m_nid, m_act;
  logic [15:0] m_done;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_scr = 0; m_dst = 0; m_src = 0; m_xl = 32'h3; m_yl = 0; m_ds = 0; m_ss = 0;
    m_mask = 2'b11; m_flags = 2'b11; m_raw = 0; m_en = 0; m_pend = 0;
    m_nid = 0; m_act = 0; m_done = 0;
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a & 12'hFFC)
      12'h000: return 32'h0004_0161;
      12'h008: return m_scr;
      12'h00C: return 32'h444D_4143;
      12'h080: return {30'b0, m_mask};
      12'h084: return {30'b0, m_raw & ~m_mask};
      12'h088: return {30'b0, m_raw};
      12'h400: return {31'b0, m_en};
      12'h404: return m_nid;
      12'h408: return {31'b0, m_pend};
      12'h40C: return {30'b0, m_flags};
      12'h410: return m_dst;
      12'h414: return m_src;
      12'h418: return m_xl;
      12'h41C: return m_yl;
      12'h420: return m_ds;
      12'h424: return m_ss;
      12'h428: return {16'b0, m_done};
      12'h42C: return m_act;
      12'h434: return DBG_DST;
      12'h438: return DBG_SRC;
      12'h43C: return {24'b0, DBG_ST};
      12'h440: return DBG_I0;
      12'h444: return DBG_I1;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    case (a & 12'hFFC)
      12'h008: m_scr = d;
      12'h080: m_mask = d[1:0];
      12'h084: m_raw = m_raw & ~d[1:0];
      12'h400: m_en = d[0];
      12'h408: if (d[0] && m_en) m_pend = 1;
      12'h40C: m_flags = d[1:0];
      12'h410: m_dst = d & 32'hFFFF_FFFE;
      12'h414: m_src = d & 32'hFFFF_FFFE;
      12'h418: m_xl = (d & 32'h00FF_FFFF) | 32'h3;
      12'h41C: m_yl = d & 32'h00FF_FFFF;
      12'h420: m_ds = d & 32'h00FF_FFFE;
      12'h424: m_ss = d & 32'h00FF_FFFE;
      default: ;
    endcase
  endtask

  // order 0: together, 1: address first, 2: data first
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input int order = 0);
    @(negedge clk);
    if (order != 2) begin s_awvalid = 1; s_awaddr = a; end
    if (order != 1) begin s_wvalid = 1; s_wdata = d; end
    @(posedge clk); #1;
    s_awvalid = 0; s_wvalid = 0;
    if (order != 0) begin
      @(negedge clk);
      chk("R4 no early bvalid", {31'b0, s_bvalid}, 32'h0);
      if (order == 1) begin s_wvalid = 1; s_wdata = d; end
      else begin s_awvalid = 1; s_awaddr = a; end
      @(posedge clk); #1;
      s_awvalid = 0; s_wvalid = 0;
    end
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    chk("R4 bvalid", {31'b0, s_bvalid}, 32'h1);
    chk("R4 bresp", {30'b0, s_bresp}, 32'h0);
    if (s_bready) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [11:0] a, input string tag);
    @(negedge clk);
    s_arvalid = 1; s_araddr = a;
    @(posedge clk); #1;
    s_arvalid = 0;
    @(negedge clk);
    chk({tag, " rvalid"}, {31'b0, s_rvalid}, 32'h1);
    chk(tag, s_rdata, exp_rd(a));
    @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk);
    req_ready = 1;
    @(posedge clk);
    if (m_pend) begin
      m_pend = 0; m_raw[0] = 1; m_done[m_nid] = 0; m_nid = (m_nid + 1) % 16;
    end
    #1 req_ready = 0;
  endtask

  task automatic finish_xfer();
    @(negedge clk);
    xfer_end = 1;
    @(posedge clk);
    m_raw[1] = 1; m_done[m_act] = 1; m_act = (m_act + 1) % 16;
    #1 xfer_end = 0;
  endtask

  task automatic read_all(input string tag);
    logic [11:0] lst [27] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h080, 12'h084,
      12'h088, 12'h400, 12'h404, 12'h408, 12'h40C, 12'h410, 12'h414, 12'h418,
      12'h41C, 12'h420, 12'h424, 12'h428, 12'h42C, 12'h430, 12'h434, 12'h438,
      12'h43C, 12'h440, 12'h444, 12'h7FC, 12'hFFC};
    foreach (lst[i]) rd_chk(lst[i], tag);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6/R7 req_valid", {31'b0, req_valid}, {31'b0, m_pend});
      chk("R9 irq", {31'b0, irq}, {31'b0, |(m_raw & ~m_mask)});
      chk("R6 req_last", {31'b0, req_last}, {31'b0, m_flags[1]});
      chk("R3 req_x_len", {8'b0, req_x_len}, m_xl);
      chk("R3 req_dst_addr", req_dst_addr, m_dst);
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    read_all("R1 reset");

    // R2 scratch and unlisted offsets
    wr(12'h008, 32'h1234_5678);
    rd_chk(12'h008, "R2 scratch");
    wr(12'h104, 32'hFFFF_FFFF);
    rd_chk(12'h104, "R2 unlisted");

    // R9 mask write, address first
    wr(12'h080, 32'h0, 1);
    rd_chk(12'h080, "R9 mask");

    // R3 fields, data first and together
    wr(12'h410, 32'hFFFF_FFFF, 2);
    wr(12'h414, 32'hFFFF_FFFF);
    wr(12'h418, 32'hFFFF_FFFF);
    wr(12'h41C, 32'hFFFF_FFFF);
    wr(12'h420, 32'hFFFF_FFFF);
    wr(12'h424, 32'hFFFF_FFFF);
    read_all("R3 ones");
    chk("R3 req_src_stride", {8'b0, req_src_stride}, m_ss);
    chk("R3 req_y_len", {8'b0, req_y_len}, m_yl);
    wr(12'h410, 32'h1357_9BDF);
    wr(12'h418, 32'h00AB_CD00);
    wr(12'h420, 32'h0000_0011);
    wr(12'h40C, 32'h1);
    read_all("R3 pattern");
    chk("R3 req_dst_stride", {8'b0, req_dst_stride}, m_ds);

    // R10 debug writes ignored
    wr(12'h434, 32'h0);
    wr(12'h43C, 32'h0);
    rd_chk(12'h434, "R10 dbg dst");
    rd_chk(12'h43C, "R10 dbg status");

    // R4 response back-pressure
    s_bready = 0;
    wr(12'h008, 32'hCAFE_0001);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 bvalid held", {31'b0, s_bvalid}, 32'h1);
      chk("R4 awready low", {30'b0, s_awready, s_wready}, 32'h0);
    end
    s_bready = 1;
    @(negedge clk);
    chk("R4 bvalid released", {31'b0, s_bvalid}, 32'h0);

    // R5 read back-pressure
    s_rready = 0;
    @(negedge clk);
    s_arvalid = 1; s_araddr = 12'h008;
    @(posedge clk); #1 s_arvalid = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 rvalid held", {31'b0, s_rvalid}, 32'h1);
      chk("R5 rdata held", s_rdata, 32'hCAFE_0001);
      chk("R5 rresp", {30'b0, s_rresp}, 32'h0);
    end
    s_rready = 1;
    @(negedge clk);
    chk("R5 rvalid released", {31'b0, s_rvalid}, 32'h0);

    // R6 submit while disabled
    wr(12'h408, 32'h1);
    rd_chk(12'h408, "R6 disabled submit");

    // R6/R7 submit, hold off, accept
    wr(12'h400, 32'h1);
    wr(12'h40C, 32'h2);
    wr(12'h408, 32'h1);
    rd_chk(12'h408, "R6 pending");
    repeat (4) @(negedge clk);
    accept();
    rd_chk(12'h408, "R7 cleared");
    rd_chk(12'h404, "R7 next id");
    rd_chk(12'h088, "R7 raw start");

    // R8 end of transfer
    finish_xfer();
    rd_chk(12'h088, "R8 raw end");
    rd_chk(12'h428, "R8 done");
    rd_chk(12'h42C, "R8 active");

    // R9 write-one-to-clear and masking
    wr(12'h084, 32'h1);
    rd_chk(12'h084, "R9 pend after clr0");
    rd_chk(12'h088, "R9 raw after clr0");
    wr(12'h084, 32'h2);
    rd_chk(12'h088, "R9 raw after clr1");
    wr(12'h080, 32'h3);
    finish_xfer();
    rd_chk(12'h088, "R9 raw masked");
    rd_chk(12'h084, "R9 pend masked");
    wr(12'h080, 32'h1);
    rd_chk(12'h084, "R9 pend unmasked");
    wr(12'h084, 32'h3);

    // R7/R8 ID wrap
    for (int n = 0; n < 17; n++) begin
      wr(12'h408, 32'h1);
      accept();
      rd_chk(12'h428, "R8 done clr on accept");
      finish_xfer();
      rd_chk(12'h404, "R7 next id wrap");
      rd_chk(12'h42C, "R8 active wrap");
      rd_chk(12'h428, "R8 done wrap");
    end

    // R11 reset restores
    wr(12'h008, 32'hDEAD_BEEF);
    wr(12'h408, 32'h1);
    @(negedge clk) rst_n = 0;
    @(posedge clk);
    model_reset();
    @(negedge clk) rst_n = 1;
    read_all("R11 after reset");

    summary();
  end
endmodule